// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt sources for a small 8-bit CPU core: two active-low external request pins, two timer overflow flags and a serial unit's receive and transmit flags, which are merged into a single source. Software writes an enable register and a priority register over a narrow register bus. Any source can be placed in a high or a low priority level. Inside a level, a fixed tie-break order applies. The controller tracks which levels are currently being serviced. A handler may therefore be interrupted only by a request of a strictly higher level.

When the CPU signals an instruction boundary and an eligible request exists, the controller drives a one-cycle take pulse together with the handler's vector address. It records the level as in service, and it clears the latched flag of an edge-sensed external request. The CPU's return-from-interrupt strobe pops the innermost level. Each external input can be set to level sensing, where the sampled pin is the request, or to falling-edge sensing, where a latched flag is the request. Both kinds of sampling happen on a machine-cycle tick.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset the enable register (address 0) and the priority register (address 1) read 0x00, the take output is 0 and the vector output is 0x0000.
- R2: No request is taken while enable bit 7 (global) is 0, whatever the per-source enable bits hold.
- R3: Enable bits 0 through 4 gate, in that order: external 0, timer 0, external 1, timer 1 and serial. A source whose bit is 0 is never taken.
- R4: The vector for source index i (0 to 4 in the order of R3) is 8*i+3, so the vectors are 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R5: Among pending enabled requests of the same level, the one with the lowest index wins.
- R6: Priority register bit i (same positions as R3) set to 1 puts source i in the high level. Any eligible high-level request wins over every low-level one. For example, with bits 2 and 3 set the order is external 1, timer 1, external 0, timer 0, serial.
- R7: While a low-level handler is in service, only a high-level request is taken. While a high-level handler is in service, nothing is taken.
- R8: A return strobe pops the innermost in-service level, and a request blocked by that level becomes eligible again.
- R9: The serial request is the OR of the receive and transmit inputs. The controller never clears them, so a flag still set after return is taken again.
- R10: With mode bit (address 2, bit 0 for external 0, bit 2 for external 1) at 0, the input is level-sensed. The request equals the inverted sampled pin, is raised again after return if the pin is still low, and ignores software writes of the flag bit.
- R11: With the mode bit at 1, a flag (address 2, bit 1 for external 0, bit 3 for external 1) is set only when a machine-cycle sample is high and the next sample is low. The flag is cleared when that source is taken.
- R12: A request is taken only in the cycle after instruction-done is high. The take output is a single-cycle pulse.
- R13: In edge mode, a software write of 1 to the flag bit produces a request that is handled exactly like a hardware-detected edge.
- R14: Enable bit 6 reads as 0 and priority bits 7 to 5 read as 0. All other implemented bits read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 enable, 1 priority, 2 external mode/flags |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| extReqN | input | 2 | Active-low external request pins |
| tmrOvf | input | 2 | Timer 0 / timer 1 overflow flags |
| serRx | input | 1 | Serial receive flag |
| serTx | input | 1 | Serial transmit flag |
| sampleTick | input | 1 | Machine-cycle strobe for pin sampling |
| instrDone | input | 1 | CPU is at an instruction boundary |
| retiStrobe | input | 1 | CPU returns from a handler |
| irqTake | output | 1 | One-cycle acknowledge with vector |
| irqVector | output | 16 | Handler vector address |

## Verification
A corrupted in-service stack shows up at the first instruction boundary after the fault. A stale high level silently blocks every later take, while a lost level lets an equal-level request appear as a nested take with the wrong vector. A wrong edge flag shows one sample tick later: in the flag read-back at address 2, and at the next boundary as a missing or repeated take. Wrong arbitration is visible directly in the vector of the very next take. For that reason each scenario drives all sources at once and walks them down by enable or priority writes.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC    = 5;
  localparam int NEXT    = 2;
  localparam int IDXW    = $clog2(NSRC);
  localparam int VECW    = 16;
  localparam int REGW    = 8;
  localparam int ADDRW   = 2;
  localparam int GIE_BIT = 7;

  localparam logic [ADDRW-1:0] ADDR_EN   = 2'd0;
  localparam logic [ADDRW-1:0] ADDR_PRI  = 2'd1;
  localparam logic [ADDRW-1:0] ADDR_MODE = 2'd2;

  typedef struct packed {
    logic            take;
    logic            takeHi;
    logic [IDXW-1:0] takeIdx;
    logic            pop;
  } ctlStrobe_t;

  function automatic logic [VECW-1:0] vecOf(input logic [IDXW-1:0] idx);
    return {{(VECW-IDXW-3){1'b0}}, idx, 3'b011};
  endfunction

  function automatic logic [IDXW-1:0] firstSet(input logic [NSRC-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_vec_dp.sv
module irq_vec_dp
  import irq_vec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDRW-1:0]    regAddr,
  input  logic [REGW-1:0]     regWdata,
  output logic [REGW-1:0]     regRdata,
  input  logic [NEXT-1:0]     extReqN,
  input  logic [1:0]          tmrOvf,
  input  logic                serRx,
  input  logic                serTx,
  input  logic                sampleTick,
  input  ctlStrobe_t          strobe,
  output logic [NSRC-1:0]     srcReq,
  output logic [NSRC-1:0]     enMask,
  output logic                gie,
  output logic [NSRC-1:0]     priMask,
  output logic                isLo,
  output logic                isHi,
  output logic                irqTake,
  output logic [VECW-1:0]     irqVector
);
  logic [REGW-1:0] enQ;
  logic [NSRC-1:0] priQ;
  logic [NEXT-1:0] extReq;
  logic [NEXT-1:0] extMode;
  logic            isLoQ, isHiQ, isLoN, isHiN;
  logic            takeQ;
  logic [VECW-1:0] vecQ;
  logic            modeWr;

  assign modeWr = regWe && (regAddr == ADDR_MODE);

  // Per-input sampling, edge latch and mode
  for (genvar g = 0; g < NEXT; g++) begin : gExt
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(2 * g);
    logic smpQ, armedQ, flagQ, modeQ;
    logic edgeHit, ackHit;

    assign edgeHit = sampleTick && armedQ && !extReqN[g] && modeQ;
    assign ackHit  = strobe.take && (strobe.takeIdx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        smpQ   <= 1'b1;
        armedQ <= 1'b0;
        flagQ  <= 1'b0;
        modeQ  <= 1'b0;
      end else begin
        if (sampleTick) begin
          smpQ   <= extReqN[g];
          armedQ <= extReqN[g];
        end
        if (modeWr) modeQ <= regWdata[2*g];
        if (modeWr)       flagQ <= regWdata[2*g+1];
        else if (edgeHit) flagQ <= 1'b1;
        else if (ackHit)  flagQ <= 1'b0;
      end
    end

    assign extReq[g]  = modeQ ? flagQ : !smpQ;
    assign extMode[g] = modeQ;
  end

  assign srcReq = {serRx | serTx, tmrOvf[1], extReq[1], tmrOvf[0], extReq[0]};

  // Enable and priority registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ  <= '0;
      priQ <= '0;
    end else if (regWe) begin
      if (regAddr == ADDR_EN)  enQ  <= regWdata & 8'hBF;
      if (regAddr == ADDR_PRI) priQ <= regWdata[NSRC-1:0];
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_EN:   regRdata = enQ;
      ADDR_PRI:  regRdata = {{(REGW-NSRC){1'b0}}, priQ};
      ADDR_MODE: regRdata = {4'b0, extReq[1], extMode[1], extReq[0], extMode[0]};
      default:   regRdata = '0;
    endcase
  end

  assign enMask  = enQ[NSRC-1:0];
  assign gie     = enQ[GIE_BIT];
  assign priMask = priQ;

  // Two-entry in-service stack: pop first, then push
  always_comb begin
    isLoN = isLoQ;
    isHiN = isHiQ;
    if (strobe.pop) begin
      if (isHiQ) isHiN = 1'b0;
      else       isLoN = 1'b0;
    end
    if (strobe.take) begin
      if (strobe.takeHi) isHiN = 1'b1;
      else               isLoN = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isLoQ <= 1'b0;
      isHiQ <= 1'b0;
      takeQ <= 1'b0;
      vecQ  <= '0;
    end else begin
      isLoQ <= isLoN;
      isHiQ <= isHiN;
      takeQ <= strobe.take;
      if (strobe.take) vecQ <= vecOf(strobe.takeIdx);
    end
  end

  assign isLo      = isLoQ;
  assign isHi      = isHiQ;
  assign irqTake   = takeQ;
  assign irqVector = vecQ;

  // R2: a take follows a cycle with global enable set
  a_r2_global_gate: assert property (@(posedge clk) disable iff (!rstN)
    takeQ |-> $past(enQ[GIE_BIT]));

  // R7: nothing is taken while a high-level handler runs
  a_r7_hi_blocks_all: assert property (@(posedge clk) disable iff (!rstN)
    (isHiQ && !strobe.pop) |=> !takeQ);

  // R8: return pops the high level first
  a_r8_pop_hi: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && isHiQ && !strobe.take) |=> (!isHiQ && ($past(isLoQ) == isLoQ)));
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_vec_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic [NSRC-1:0] enMask,
  input  logic            gie,
  input  logic [NSRC-1:0] priMask,
  input  logic            isLo,
  input  logic            isHi,
  input  logic            instrDone,
  input  logic            retiStrobe,
  output ctlStrobe_t      strobe
);
  logic [NSRC-1:0] eligible, hiReq, loReq;
  logic            hiOk, loOk, hiWin, loWin;

  assign eligible = srcReq & enMask & {NSRC{gie}};
  assign hiReq    = eligible & priMask;
  assign loReq    = eligible & ~priMask;
  assign hiOk     = !isHi;
  assign loOk     = !isHi && !isLo;
  assign hiWin    = hiOk && (|hiReq);
  assign loWin    = loOk && (|loReq);

  always_comb begin
    strobe.take    = instrDone && (hiWin || loWin);
    strobe.takeHi  = hiWin;
    strobe.takeIdx = hiWin ? firstSet(hiReq) : firstSet(loReq);
    strobe.pop     = retiStrobe;
  end

  // R6: a low-level grant never occurs while a high request is eligible and allowed
  a_r6_hi_before_lo: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.take && !strobe.takeHi) |-> !(hiOk && (|(srcReq & enMask & priMask))));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [REGW-1:0]  regWdata,
  output logic [REGW-1:0]  regRdata,
  input  logic [NEXT-1:0]  extReqN,
  input  logic [1:0]       tmrOvf,
  input  logic             serRx,
  input  logic             serTx,
  input  logic             sampleTick,
  input  logic             instrDone,
  input  logic             retiStrobe,
  output logic             irqTake,
  output logic [VECW-1:0]  irqVector
);
  ctlStrobe_t      strobe;
  logic [NSRC-1:0] srcReq, enMask, priMask;
  logic            gie, isLo, isHi;

  irq_vec_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extReqN(extReqN),
    .tmrOvf(tmrOvf), .serRx(serRx), .serTx(serTx), .sampleTick(sampleTick),
    .strobe(strobe), .srcReq(srcReq), .enMask(enMask), .gie(gie),
    .priMask(priMask), .isLo(isLo), .isHi(isHi),
    .irqTake(irqTake), .irqVector(irqVector)
  );

  irq_vec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .enMask(enMask), .gie(gie),
    .priMask(priMask), .isLo(isLo), .isHi(isHi), .instrDone(instrDone),
    .retiStrobe(retiStrobe), .strobe(strobe)
  );

  // R12: every take follows an instruction boundary
  a_r12_take_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> $past(instrDone));

  // R4: the vector of a take is one of the five handler slots
  a_r4_vector_slot: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (irqVector[2:0] == 3'b011 && irqVector[VECW-1:6] == '0
                 && irqVector[5:3] <= 3'd4));
endmodule

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata;
  logic [1:0]  extReqN = 2'b11;
  logic [1:0]  tmrOvf = '0;
  logic        serRx = 1'b0, serTx = 1'b0;
  logic        sampleTick = 1'b1;
  logic        instrDone = 1'b0, retiStrobe = 1'b0;
  logic        irqTake;
  logic [15:0] irqVector;
  int          nRun = 0, nFail = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_vec_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extReqN(extReqN),
    .tmrOvf(tmrOvf), .serRx(serRx), .serTx(serTx), .sampleTick(sampleTick),
    .instrDone(instrDone), .retiStrobe(retiStrobe),
    .irqTake(irqTake), .irqVector(irqVector)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
    regAddr = a; #1;
    chk(tag, {8'h0, regRdata}, {8'h0, exp});
  endtask

  task automatic tryTake(input string tag, input logic expTake, input logic [15:0] expVec);
    @(negedge clk); instrDone = 1'b1;
    @(negedge clk); instrDone = 1'b0;
    chk({tag, " take"}, {15'h0, irqTake}, {15'h0, expTake});
    if (expTake) chk({tag, " vector"}, irqVector, expVec);
  endtask

  task automatic reti();
    @(negedge clk); retiStrobe = 1'b1;
    @(negedge clk); retiStrobe = 1'b0;
  endtask

  task automatic clean();
    extReqN = 2'b11; tmrOvf = '0; serRx = 1'b0; serTx = 1'b0; sampleTick = 1'b1;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    reti(); reti(); step(2);
  endtask

  task automatic tReset();
    step(1);
    rd(2'd0, "R1 enable after reset", 8'h00);
    rd(2'd1, "R1 priority after reset", 8'h00);
    chk("R1 take after reset", {15'h0, irqTake}, 16'h0);
    chk("R1 vector after reset", irqVector, 16'h0000);
  endtask

  task automatic tGlobal();
    tmrOvf[0] = 1'b1;
    wr(2'd0, 8'h02);
    tryTake("R2 global off", 1'b0, 16'h0);
    wr(2'd0, 8'h80);
    tryTake("R3 source bit off", 1'b0, 16'h0);
    wr(2'd0, 8'h82);
    tryTake("R2 global on", 1'b1, 16'h000B);
    clean();
  endtask

  task automatic tOrder();
    extReqN = 2'b00; tmrOvf = 2'b11; serRx = 1'b1;
    step(2);
    wr(2'd0, 8'h9F); tryTake("R5 order ext0", 1'b1, 16'h0003); reti();
    wr(2'd0, 8'h9E); tryTake("R4 timer0 vec", 1'b1, 16'h000B); reti();
    wr(2'd0, 8'h9C); tryTake("R4 ext1 vec", 1'b1, 16'h0013); reti();
    wr(2'd0, 8'h98); tryTake("R4 timer1 vec", 1'b1, 16'h001B); reti();
    wr(2'd0, 8'h90); tryTake("R4 serial vec", 1'b1, 16'h0023); reti();
    clean();
  endtask

  task automatic tPriority();
    extReqN = 2'b00; tmrOvf = 2'b11; serRx = 1'b1;
    step(2);
    wr(2'd1, 8'h0C); wr(2'd0, 8'h9F);
    tryTake("R6 high ext1 first", 1'b1, 16'h0013);
    tryTake("R7 no preempt of high", 1'b0, 16'h0);
    reti();
    wr(2'd0, 8'h9B);
    tryTake("R6 high timer1 next", 1'b1, 16'h001B);
    reti();
    wr(2'd0, 8'h93);
    tryTake("R6 low ext0 after high", 1'b1, 16'h0003);
    tryTake("R7 low cannot preempt low", 1'b0, 16'h0);
    wr(2'd0, 8'h9F);
    tryTake("R7 high preempts low", 1'b1, 16'h0013);
    wr(2'd0, 8'h93);
    reti();
    tryTake("R8 low still in service", 1'b0, 16'h0);
    reti();
    tryTake("R8 after both returns", 1'b1, 16'h0003);
    clean();
  endtask

  task automatic tSerial();
    serTx = 1'b1;
    wr(2'd0, 8'h90);
    tryTake("R9 transmit flag", 1'b1, 16'h0023);
    reti();
    tryTake("R9 flag not cleared", 1'b1, 16'h0023);
    reti();
    serTx = 1'b0; serRx = 1'b1;
    tryTake("R9 receive flag", 1'b1, 16'h0023);
    clean();
  endtask

  task automatic tLevel();
    wr(2'd0, 8'h81);
    extReqN[0] = 1'b0; step(2);
    tryTake("R10 level low", 1'b1, 16'h0003);
    extReqN[0] = 1'b1; step(2);
    reti();
    tryTake("R10 released before return", 1'b0, 16'h0);
    extReqN[0] = 1'b0; step(2);
    tryTake("R10 low again", 1'b1, 16'h0003);
    reti();
    tryTake("R10 still low re-raises", 1'b1, 16'h0003);
    reti();
    extReqN[0] = 1'b1; step(2);
    wr(2'd0, 8'h84);
    wr(2'd2, 8'h08);
    tryTake("R10 level ignores flag write", 1'b0, 16'h0);
    clean();
  endtask

  task automatic tEdge();
    wr(2'd2, 8'h01); wr(2'd0, 8'h81);
    step(2);
    sampleTick = 1'b0; extReqN[0] = 1'b0; step(3);
    tryTake("R11 no sample no edge", 1'b0, 16'h0);
    rd(2'd2, "R11 flag clear before tick", 8'h01);
    @(negedge clk); sampleTick = 1'b1;
    step(1);
    rd(2'd2, "R11 flag set on edge", 8'h03);
    tryTake("R11 edge taken", 1'b1, 16'h0003);
    rd(2'd2, "R11 flag cleared on take", 8'h01);
    reti();
    tryTake("R11 held low no retrigger", 1'b0, 16'h0);
    clean();
  endtask

  task automatic tSoft();
    wr(2'd0, 8'h81);
    wr(2'd2, 8'h03);
    tryTake("R13 software flag ext0", 1'b1, 16'h0003);
    rd(2'd2, "R13 software flag cleared", 8'h01);
    reti();
    wr(2'd0, 8'h84);
    wr(2'd2, 8'h0C);
    tryTake("R13 software flag ext1", 1'b1, 16'h0013);
    clean();
  endtask

  task automatic tBoundary();
    tmrOvf[0] = 1'b1;
    wr(2'd0, 8'h82);
    step(5);
    chk("R12 no take without boundary", {15'h0, irqTake}, 16'h0);
    tryTake("R12 take at boundary", 1'b1, 16'h000B);
    step(1);
    chk("R12 single-cycle pulse", {15'h0, irqTake}, 16'h0);
    clean();
  endtask

  task automatic tReadback();
    wr(2'd0, 8'hFF); rd(2'd0, "R14 enable readback", 8'hBF);
    wr(2'd1, 8'hFF); rd(2'd1, "R14 priority readback", 8'h1F);
    clean();
  endtask

  initial begin
    #(CLK_P * 100000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    step(3);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tGlobal();
    tOrder();
    tPriority();
    tSerial();
    tLevel();
    tEdge();
    tSoft();
    tBoundary();
    tReadback();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule